// File: doc/BRIEF.md
# SPI Register Bank Slave

This block is an SPI slave that exposes a bank of 64 registers, each 24 bits wide, to an external master. Every transaction is one fixed 32-bit frame. The first bits the master sends are a direction flag and a 6-bit register address. The last 24 bit positions carry the data.

On a write frame, the slave stores the data when the final bit arrives. On a read frame, the slave sends the addressed register back in the low 24 bit positions of that same frame. The master therefore gets a read result without a second transfer.

Most registers are plain storage. Five addresses are special:

- Two interrupt status registers collect per-bit event pulses. Software clears a status bit by writing 1 to it.
- Two mask registers decide which status bits may raise the level interrupt output.
- One read-only register reports a revision and identification word.

The SPI pins are sampled by the system clock. This keeps the whole block in one clock domain. The SPI clock must therefore run well below the system clock.

Top module: `spi_regbank`

## Requirements
- R1: A frame is 32 bits, sent most significant bit first. Bit 31 = 1 means write and bit 31 = 0 means read. Bits 30:25 hold the register address. Bit 24 is ignored. Bits 23:0 carry the data. A write frame stores bits 23:0 in the addressed register.
- R2: In a read frame, the slave returns the addressed register in bits 23:0 of the same frame, with bits 31:24 returned as 0. The data bits the master sends during a read frame change no register.
- R3: Timing follows SPI mode 0. The clock idles low and chip select is active high. MOSI is sampled on the rising SCLK edge. MISO changes only after a falling SCLK edge, or to 0 when chip select drops.
- R4: A frame is discarded if chip select falls before the 32nd rising SCLK edge. No register changes in that case.
- R5: After reset, both mask registers read 0xFFFFFF and both status registers read 0. All other registers read 0, MISO is 0 and the interrupt output is low.
- R6: Status register A is at address 0x00 and status register B is at 0x03. A 1 on a bit of event input A or B, held for one clock, sets the matching status bit. Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R7: If an event and a write-1-to-clear hit the same status bit in the same clock, the bit stays set.
- R8: Mask A is at address 0x01 and mask B is at 0x04. A mask bit of 1 blocks the matching status bit. The interrupt output is high exactly while some status bit is set with its mask bit at 0.
- R9: Address 0x07 is the read-only revision register. Its layout is:
  - bits 2:0: minor revision (default 2)
  - bits 4:3: major revision (default 3)
  - bits 8:6: the fixed IC identifier 2
  - bits 12:9: the fab identifier (default 5)
  - all other bits: 0

  With the default parameters it reads 0x000A9A. Writes to it are ignored.
- R10: Every address other than 0x00, 0x01, 0x03, 0x04 and 0x07, including 0x3F, is plain 24-bit storage. A write to one address leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock, idles low |
| spi_cs | input | 1 | Chip select, active high, one frame per assertion |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| irq_ev_a | input | 24 | Per-bit event pulses that set status register A |
| irq_ev_b | input | 24 | Per-bit event pulses that set status register B |
| irq_out | output | 1 | Level interrupt: any unmasked status bit set |

## Verification
An event pulse that sets a status bit can arrive in the same clock in which a write frame commits a write-1-to-clear to that same bit. The bench places the event pulse exactly on the commit clock. It does this by counting the synchronizer stages from the final rising SCLK edge.

The result is judged by reading the status register back in a later frame, which must still show the bit set. A second case clears one bit while an event sets a different bit. That case shows that the clear still works on bits the event does not touch.

// File: rtl/spi_regbank.sv
`timescale 1ns/1ps
module spi_regbank #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 24,
  parameter logic [ADDR_W-1:0] ADR_ST_A  = ADDR_W'(0),
  parameter logic [ADDR_W-1:0] ADR_MSK_A = ADDR_W'(1),
  parameter logic [ADDR_W-1:0] ADR_ST_B  = ADDR_W'(3),
  parameter logic [ADDR_W-1:0] ADR_MSK_B = ADDR_W'(4),
  parameter logic [ADDR_W-1:0] ADR_REV   = ADDR_W'(7),
  parameter int REV_MINOR = 2,
  parameter int REV_MAJOR = 3,
  parameter int FAB_ID    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic [DATA_W-1:0] irq_ev_a,
  input  logic [DATA_W-1:0] irq_ev_b,
  output logic              irq_out
);
  localparam int FRAME_W = DATA_W + ADDR_W + 2;
  localparam int CNT_W   = $clog2(FRAME_W) + 1;
  localparam int NREG    = 2 ** ADDR_W;
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(ADDR_W + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [DATA_W-1:0] REV_WORD =
    DATA_W'(((FAB_ID & 15) << 9) | (2 << 6) | ((REV_MAJOR & 3) << 3) | (REV_MINOR & 7));

  logic [2:0] sclk_q;
  logic [1:0] cs_q, mosi_q;
  logic [CNT_W-1:0] cnt;
  logic [FRAME_W-2:0] sh;
  logic [DATA_W-1:0] tx, rd_word;
  logic miso_q;
  logic [DATA_W-1:0] st_a, st_b, mk_a, mk_b;
  logic [DATA_W-1:0] mem [NREG];

  wire rise  = sclk_q[1] & ~sclk_q[2];
  wire fall  = ~sclk_q[1] & sclk_q[2];
  wire cs_on = cs_q[1];
  wire din   = mosi_q[1];
  wire take  = cs_on & rise & (cnt != CNT_FULL);
  wire hdr   = take & (cnt == CNT_HDR);
  wire wr    = take & (cnt == CNT_LAST) & sh[FRAME_W-2];
  wire [ADDR_W-1:0] ra = sh[ADDR_W-1:0];
  wire [ADDR_W-1:0] wa = sh[FRAME_W-3 -: ADDR_W];
  wire [DATA_W-1:0] wd = {sh[DATA_W-2:0], din};
  wire [DATA_W-1:0] clr_a = (wr && wa == ADR_ST_A) ? wd : '0;
  wire [DATA_W-1:0] clr_b = (wr && wa == ADR_ST_B) ? wd : '0;

  assign spi_miso = miso_q;
  assign irq_out  = |(st_a & ~mk_a) | |(st_b & ~mk_b);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_q <= '0;
      cs_q   <= '0;
      mosi_q <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], spi_sclk};
      cs_q   <= {cs_q[0], spi_cs};
      mosi_q <= {mosi_q[0], spi_mosi};
    end

  always_comb
    case (ra)
      ADR_ST_A:  rd_word = st_a;
      ADR_MSK_A: rd_word = mk_a;
      ADR_ST_B:  rd_word = st_b;
      ADR_MSK_B: rd_word = mk_b;
      ADR_REV:   rd_word = REV_WORD;
      default:   rd_word = mem[ra];
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt    <= '0;
      sh     <= '0;
      tx     <= '0;
      miso_q <= 1'b0;
    end else if (!cs_on) begin
      cnt    <= '0;
      miso_q <= 1'b0;
    end else begin
      if (take) begin
        sh  <= {sh[FRAME_W-3:0], din};
        cnt <= cnt + 1'b1;
      end
      if (hdr)
        tx <= rd_word;
      else if (fall && cnt > CNT_HDR) begin
        miso_q <= tx[DATA_W-1];
        tx     <= {tx[DATA_W-2:0], 1'b0};
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st_a <= '0;
      st_b <= '0;
      mk_a <= '1;
      mk_b <= '1;
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else begin
      st_a <= (st_a & ~clr_a) | irq_ev_a;
      st_b <= (st_b & ~clr_b) | irq_ev_b;
      if (wr) begin
        if (wa == ADR_MSK_A) mk_a <= wd;
        if (wa == ADR_MSK_B) mk_b <= wd;
        mem[wa] <= wd;
      end
    end
endmodule

// File: rtl/spi_regbank_chk.sv
`timescale 1ns/1ps
module spi_regbank_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 24,
  parameter logic [ADDR_W-1:0] ADR_ST_A  = ADDR_W'(0),
  parameter logic [ADDR_W-1:0] ADR_MSK_A = ADDR_W'(1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rise,
  input logic              fall,
  input logic              cs_on,
  input logic              miso,
  input logic              wr,
  input logic [ADDR_W-1:0] wa,
  input logic [DATA_W-1:0] wd,
  input logic [DATA_W-1:0] st_a,
  input logic [DATA_W-1:0] mk_a,
  input logic [DATA_W-1:0] ev_a
);
  localparam int FRAME_W = DATA_W + ADDR_W + 2;
  int unsigned edges;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) edges <= 0;
    else if (!cs_on) edges <= 0;
    else if (rise && edges < 1000) edges <= edges + 1;

  // R3
  miso_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_on && $past(cs_on) && !$stable(miso)) |-> $past(fall));

  // R4
  full_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |-> (cs_on && edges == FRAME_W - 1));

  // R7
  ev_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_a) |=> ((st_a & $past(ev_a)) == $past(ev_a)));

  // R6
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_a & ~$past(st_a) & ~$past(ev_a)) == '0));

  // R6
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wa == ADR_ST_A && ev_a == '0) |=> ((st_a & $past(wd)) == '0));

  // R8
  mask_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wa == ADR_MSK_A) |=> (mk_a == $past(wd)));
endmodule

bind spi_regbank spi_regbank_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ADR_ST_A(ADR_ST_A), .ADR_MSK_A(ADR_MSK_A)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall), .cs_on(cs_on),
  .miso(miso_q), .wr(wr), .wa(wa), .wd(wd), .st_a(st_a), .mk_a(mk_a),
  .ev_a(irq_ev_a)
);

// File: tb/sim_spi_regbank.sv
`timescale 1ns/1ps
module sim_spi_regbank;
  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_sclk = 1'b0, spi_cs = 1'b0, spi_mosi = 1'b0;
  logic [23:0] ev_a = '0, ev_b = '0;
  wire spi_miso, irq_out;

  int n_cmp = 0, n_bad = 0, m_cmp = 0, m_bad = 0;

  typedef struct {
    bit          chk;
    logic [31:0] exp;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  spi_regbank u0 (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs(spi_cs),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .irq_ev_a(ev_a),
    .irq_ev_b(ev_b), .irq_out(irq_out)
  );

  function automatic logic [31:0] wfr(input logic [5:0] a, input logic [23:0] d);
    return {1'b1, a, 1'b0, d};
  endfunction

  function automatic logic [31:0] rfr(input logic [5:0] a, input logic [23:0] d);
    return {1'b0, a, 1'b0, d};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] word, input int nb, input bit chk,
                      input logic [23:0] expd, input string tag,
                      input logic [23:0] evm = '0);
    exp_t it;
    it.chk = chk;
    it.exp = {8'h00, expd};
    it.tag = tag;
    sb.push_back(it);
    spi_cs = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      spi_mosi = word[31-i];
      repeat (4) @(negedge clk);
      spi_sclk = 1'b1;
      for (int j = 0; j < 4; j++) begin
        @(negedge clk);
        if (i == nb - 1 && j == 1) ev_a = evm;
        if (j == 2) ev_a = '0;
      end
      spi_sclk = 1'b0;
    end
    repeat (4) @(negedge clk);
    spi_cs = 1'b0;
    spi_mosi = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [23:0] d, input logic [23:0] evm = '0);
    xfer(wfr(a, d), 32, 1'b0, '0, "", evm);
  endtask

  task automatic rd(input logic [5:0] a, input logic [23:0] expd, input string tag);
    xfer(rfr(a, 24'h0), 32, 1'b1, expd, tag);
  endtask

  task automatic pulse(input bit which_b, input logic [23:0] m);
    @(negedge clk);
    if (which_b) ev_b = m; else ev_a = m;
    @(negedge clk);
    ev_a = '0;
    ev_b = '0;
  endtask

  initial begin : monitor
    logic [31:0] rx;
    exp_t it;
    rx = '0;
    forever begin
      @(posedge spi_sclk or negedge spi_cs);
      if (spi_cs) rx = {rx[30:0], spi_miso};
      else begin
        if (sb.size() > 0) begin
          it = sb.pop_front();
          if (it.chk) begin
            m_cmp++;
            if (rx !== it.exp) begin
              m_bad++;
              $display("FAIL %s actual=%h expected=%h", it.tag, rx, it.exp);
            end
          end
        end
        rx = '0;
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + m_cmp + 1, n_bad + m_bad + 1);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R5 reset state
    check("R5 irq", {31'b0, irq_out}, 32'h0);
    check("R5 miso", {31'b0, spi_miso}, 32'h0);
    rd(6'h00, 24'h000000, "R5 status A");
    rd(6'h01, 24'hFFFFFF, "R5 mask A");
    rd(6'h03, 24'h000000, "R5 status B");
    rd(6'h04, 24'hFFFFFF, "R5 mask B");
    rd(6'h25, 24'h000000, "R5 plain reg");

    // R10 plain storage
    wr(6'h3F, 24'hA5C3F1);
    wr(6'h10, 24'h123456);
    rd(6'h3F, 24'hA5C3F1, "R10 addr 3F");
    rd(6'h10, 24'h123456, "R10 addr 10");
    wr(6'h3E, 24'h000000);
    rd(6'h3F, 24'hA5C3F1, "R10 neighbour unchanged");

    // R1 bit 24 ignored
    xfer({1'b1, 6'h11, 1'b1, 24'h00BEEF}, 32, 1'b0, '0, "");
    rd(6'h11, 24'h00BEEF, "R1 write with bit24 set");

    // R2 data bits in read frame do not write
    xfer(rfr(6'h10, 24'hFFFFFF), 32, 1'b1, 24'h123456, "R2 read with data bits");
    rd(6'h10, 24'h123456, "R2 no write from read");

    // R9 revision read-only
    rd(6'h07, 24'h000A9A, "R9 revision");
    wr(6'h07, 24'hFFFFFF);
    rd(6'h07, 24'h000A9A, "R9 revision after write");

    // R4 short frames discarded
    xfer(wfr(6'h10, 24'h654321), 31, 1'b0, '0, "");
    xfer(wfr(6'h10, 24'h0F0F0F), 8, 1'b0, '0, "");
    rd(6'h10, 24'h123456, "R4 short frames");

    // R6 set and write-1-clear
    pulse(1'b0, 24'h000220);
    rd(6'h00, 24'h000220, "R6 events set");
    check("R8 masked irq low", {31'b0, irq_out}, 32'h0);
    wr(6'h00, 24'h000020);
    rd(6'h00, 24'h000200, "R6 clear one bit");
    wr(6'h00, 24'h000000);
    rd(6'h00, 24'h000200, "R6 write zero keeps");

    // R8 masking and level interrupt
    wr(6'h01, 24'hFFFDFF);
    check("R8 unmasked irq high", {31'b0, irq_out}, 32'h1);
    wr(6'h01, 24'hFFFFFF);
    check("R8 remasked irq low", {31'b0, irq_out}, 32'h0);
    pulse(1'b1, 24'h800000);
    rd(6'h03, 24'h800000, "R6 status B set");
    check("R8 B masked", {31'b0, irq_out}, 32'h0);
    wr(6'h04, 24'h7FFFFF);
    check("R8 B unmasked", {31'b0, irq_out}, 32'h1);
    wr(6'h03, 24'h800000);
    check("R8 B cleared", {31'b0, irq_out}, 32'h0);
    rd(6'h03, 24'h000000, "R6 status B cleared");

    // R7 event wins over same-cycle clear
    wr(6'h00, 24'h000200, 24'h000200);
    rd(6'h00, 24'h000200, "R7 event beats clear");
    wr(6'h00, 24'h000200, 24'h000001);
    rd(6'h00, 24'h000001, "R7 other bit clears");

    // R3 idle miso
    check("R3 miso idle", {31'b0, spi_miso}, 32'h0);

    repeat (10) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + m_cmp, n_bad + m_bad);
    $finish;
  end
endmodule